// File: doc/BRIEF.md
# Power Shutdown Sequencing Controller

This block decides when the system is shut down and runs the reset sequence that follows. There are three causes. The first is a start-up watchdog that software must keep clearing. The second is a software sleep request, which is honoured only when no interrupt is pending. The third is a battery-inhibit input sampled while the CPU is being activated. Each cause drives its own ordered sequence on separate reset outputs for the general peripheral group, the GPIO unit and the CPU core, plus a CPU clock-stop output. The real-time clock and the controller itself are never reset by any of these sequences, so neither has an output here.

The watchdog runs only while the CPU is running. It counts pulses of a slow always-on tick, and its terminal count is a parameter. It is reloaded each time the CPU enters the running state, whether through activation from the off state, completion of a watchdog restart, or a reset-switch restart. A small two-address register port lets software clear the watchdog and read or clear the sticky cause flags. There is no streaming data path, so every pin is a plain control or status level or pulse.

Top module: `pwr_shutdown_seq`

## Requirements
- R1: While `rst_n` is low and after it is released, `cpu_rst` is 1 and `periph_rst`, `gpio_rst` and `cpu_clk_stop` are 0, and both status flags read 0. After `ACT_CYCLES` cycles of activation, all four outputs are 0 (running).
- R2: While running, the watchdog counts `slow_tick` pulses. The `WD_LIMIT`-th pulse since the last reload starts a watchdog shutdown. Writing 1 to bit 0 at address 0 reloads the count.
- R3: A watchdog shutdown holds `periph_rst` and `gpio_rst` for `HOLD_CYCLES` cycles. It then holds `cpu_rst` together with both of them for `HOLD_CYCLES` cycles, then activates (only `cpu_rst`) for `ACT_CYCLES` cycles and returns to running. It sets the timeout flag, status bit 0.
- R4: A `hib_req` pulse while `irq_pending` is 1 is ignored; the outputs stay all 0.
- R5: A `hib_req` pulse with no pending interrupt asserts `cpu_clk_stop` alone for 1 cycle. It then adds `periph_rst` for `HOLD_CYCLES` cycles and leaves only `cpu_clk_stop` asserted (off). It never touches `gpio_rst` and leaves both status flags unchanged.
- R6: The watchdog does not count while off or during any sequence. Its count restarts from zero on every entry to running.
- R7: An `activate_req` pulse while off starts an `ACT_CYCLES` activation followed by running. A `reset_switch` pulse while running does the same.
- R8: `batt_inhibit` high during activation aborts it. The block holds `periph_rst` alone for `HOLD_CYCLES` cycles, then `periph_rst` with `cpu_rst` for `HOLD_CYCLES` cycles, then goes off, and sets the battery flag, status bit 1. `batt_inhibit` has no effect outside activation.
- R9: At address 1, writing 0 to a flag bit clears that flag and writing 1 leaves it unchanged. A hardware set in the same cycle wins over a clear. Address 1 reads {battery flag, timeout flag} and address 0 reads 0.
- R10: `gpio_rst` is never high without `periph_rst`. In each shutdown sequence, `periph_rst` is high for at least one cycle before `cpu_rst` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slow_tick | input | 1 | One-cycle pulse per slow always-on clock period |
| activate_req | input | 1 | Wake pulse; starts activation while off |
| reset_switch | input | 1 | Reset-switch pulse; restarts the CPU while running |
| hib_req | input | 1 | Software sleep request pulse |
| irq_pending | input | 1 | Any interrupt request pending |
| batt_inhibit | input | 1 | Battery-inhibit level |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0: control, 1: status |
| reg_wdata | input | 2 | Write data |
| reg_rdata | output | 2 | Read data for `reg_addr` |
| periph_rst | output | 1 | Reset to the general peripheral group |
| gpio_rst | output | 1 | Reset to the GPIO unit |
| cpu_rst | output | 1 | Cold reset to the CPU core |
| cpu_clk_stop | output | 1 | Stops the CPU core clock |

## Verification
The hardest case is the collision between a hardware flag set and a software clear of the same flag in one cycle. The set is only visible for the single cycle in which activation sees `batt_inhibit`. The stimulus holds `batt_inhibit` high before the wake pulse, so the abort falls on the first activation cycle. It places the status write of 0 exactly on that edge, then reads the flag back. The watchdog reload on a reset-switch restart is also forced deliberately: ticks are spent before the restart and more after it, so their total exceeds the limit while neither side does.

// File: rtl/pss_pkg.sv
package pss_pkg;
  typedef enum logic [3:0] {
    ST_ACT,
    ST_RUN,
    ST_WD_PERI,
    ST_WD_CPU,
    ST_HIB_STOP,
    ST_HIB_PERI,
    ST_OFF,
    ST_BI_PERI,
    ST_BI_CPU
  } seq_state_t;

  typedef struct packed {
    logic clk_stop;
    logic cpu_rst;
    logic gpio_rst;
    logic periph_rst;
  } rst_vec_t;

  localparam int REG_W = 2;
  localparam logic ADDR_CTRL = 1'b0;
  localparam logic ADDR_STAT = 1'b1;
  localparam int BIT_WD_CLR = 0;
  localparam int BIT_TMO = 0;
  localparam int BIT_BATT = 1;
endpackage

// File: rtl/pss_wdog.sv
module pss_wdog #(
  parameter int WD_LIMIT = 131072
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic clr,
  input  logic tick,
  output logic timeout
);
  localparam int CW = $clog2(WD_LIMIT + 1);
  localparam logic [CW-1:0] LAST = CW'(WD_LIMIT - 1);

  logic [CW-1:0] cnt;

  assign timeout = arm && tick && !clr && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (!arm || clr || timeout) begin
      cnt <= '0;
    end else if (tick) begin
      cnt <= cnt + 1'b1;
    end
  end

  // R6: a disarmed watchdog holds a zero count
  a_r6_idle_when_disarmed: assert property (@(posedge clk) disable iff (!rst_n)
    !arm |=> (cnt == '0));
  // R2: a software clear restarts the count
  a_r2_clear_reloads: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt == '0));
endmodule

// File: rtl/pss_regs.sv
module pss_regs
  import pss_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             addr,
  input  logic [REG_W-1:0] wdata,
  input  logic             set_tmo,
  input  logic             set_batt,
  output logic [REG_W-1:0] rdata,
  output logic             wd_clr
);
  logic tmo_flag, batt_flag;
  logic stat_wr;

  assign stat_wr = wr_en && (addr == ADDR_STAT);
  assign wd_clr  = wr_en && (addr == ADDR_CTRL) && wdata[BIT_WD_CLR];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmo_flag  <= 1'b0;
      batt_flag <= 1'b0;
    end else begin
      if (set_tmo) tmo_flag <= 1'b1;
      else if (stat_wr && !wdata[BIT_TMO]) tmo_flag <= 1'b0;
      if (set_batt) batt_flag <= 1'b1;
      else if (stat_wr && !wdata[BIT_BATT]) batt_flag <= 1'b0;
    end
  end

  always_comb begin
    rdata = '0;
    if (addr == ADDR_STAT) begin
      rdata[BIT_TMO]  = tmo_flag;
      rdata[BIT_BATT] = batt_flag;
    end
  end

  // R9: a hardware set always lands, even against a clear
  a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    set_batt |=> batt_flag);
  // R9: a write of 1 never clears a flag
  a_r9_write_one_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_wr && wdata[BIT_TMO] && tmo_flag) |=> tmo_flag);
endmodule

// File: rtl/pss_seq.sv
module pss_seq
  import pss_pkg::*;
#(
  parameter int HOLD_CYCLES = 16,
  parameter int ACT_CYCLES  = 8
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     timeout,
  input  logic     hib_req,
  input  logic     irq_pending,
  input  logic     batt_inhibit,
  input  logic     activate_req,
  input  logic     reset_switch,
  output rst_vec_t vec,
  output logic     running,
  output logic     set_batt
);
  localparam int MAXC = (HOLD_CYCLES > ACT_CYCLES) ? HOLD_CYCLES : ACT_CYCLES;
  localparam int HCW  = $clog2(MAXC + 1);
  localparam logic [HCW-1:0] HOLD_LAST = HCW'(HOLD_CYCLES - 1);
  localparam logic [HCW-1:0] ACT_LAST  = HCW'(ACT_CYCLES - 1);

  seq_state_t state, nxt;
  logic [HCW-1:0] cnt;
  logic hold_done, act_done, timed;

  assign hold_done = (cnt == HOLD_LAST);
  assign act_done  = (cnt == ACT_LAST);
  assign timed     = (state != ST_RUN) && (state != ST_OFF);
  assign running   = (state == ST_RUN);
  assign set_batt  = (state == ST_ACT) && batt_inhibit;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_ACT:      if (batt_inhibit) nxt = ST_BI_PERI;
                   else if (act_done) nxt = ST_RUN;
      ST_RUN:      if (timeout) nxt = ST_WD_PERI;
                   else if (reset_switch) nxt = ST_ACT;
                   else if (hib_req && !irq_pending) nxt = ST_HIB_STOP;
      ST_WD_PERI:  if (hold_done) nxt = ST_WD_CPU;
      ST_WD_CPU:   if (hold_done) nxt = ST_ACT;
      ST_HIB_STOP: nxt = ST_HIB_PERI;
      ST_HIB_PERI: if (hold_done) nxt = ST_OFF;
      ST_OFF:      if (activate_req) nxt = ST_ACT;
      ST_BI_PERI:  if (hold_done) nxt = ST_BI_CPU;
      ST_BI_CPU:   if (hold_done) nxt = ST_OFF;
      default:     nxt = ST_OFF;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_ACT;
      cnt   <= '0;
    end else begin
      state <= nxt;
      if (nxt != state) cnt <= '0;
      else if (timed) cnt <= cnt + 1'b1;
    end
  end

  always_comb begin
    vec = '0;
    unique case (state)
      ST_ACT:      vec.cpu_rst = 1'b1;
      ST_WD_PERI:  begin vec.periph_rst = 1'b1; vec.gpio_rst = 1'b1; end
      ST_WD_CPU:   begin vec.periph_rst = 1'b1; vec.gpio_rst = 1'b1; vec.cpu_rst = 1'b1; end
      ST_HIB_STOP: vec.clk_stop = 1'b1;
      ST_HIB_PERI: begin vec.clk_stop = 1'b1; vec.periph_rst = 1'b1; end
      ST_OFF:      vec.clk_stop = 1'b1;
      ST_BI_PERI:  vec.periph_rst = 1'b1;
      ST_BI_CPU:   begin vec.periph_rst = 1'b1; vec.cpu_rst = 1'b1; end
      default:     vec = '0;
    endcase
  end

  // R4: a sleep request with a pending interrupt leaves the CPU running
  a_r4_irq_blocks_sleep: assert property (@(posedge clk) disable iff (!rst_n)
    (running && hib_req && irq_pending && !timeout && !reset_switch) |=> running);
  // R8: an abort never lets activation reach running
  a_r8_abort_not_running: assert property (@(posedge clk) disable iff (!rst_n)
    set_batt |=> (!running && vec.periph_rst && !vec.cpu_rst));
  // R5: the clock stop leads the peripheral reset into sleep
  a_r5_stop_then_periph: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_HIB_STOP) |=> (vec.clk_stop && vec.periph_rst && !vec.gpio_rst));
endmodule

// File: rtl/pwr_shutdown_seq.sv
module pwr_shutdown_seq
  import pss_pkg::*;
#(
  parameter int WD_LIMIT    = 131072,
  parameter int HOLD_CYCLES = 16,
  parameter int ACT_CYCLES  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             slow_tick,
  input  logic             activate_req,
  input  logic             reset_switch,
  input  logic             hib_req,
  input  logic             irq_pending,
  input  logic             batt_inhibit,
  input  logic             reg_wr_en,
  input  logic             reg_addr,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  output logic             periph_rst,
  output logic             gpio_rst,
  output logic             cpu_rst,
  output logic             cpu_clk_stop
);
  logic     running, timeout, wd_clr, set_batt;
  rst_vec_t vec;

  pss_wdog #(.WD_LIMIT(WD_LIMIT)) u_wdog (
    .clk(clk), .rst_n(rst_n), .arm(running), .clr(wd_clr),
    .tick(slow_tick), .timeout(timeout)
  );

  pss_seq #(.HOLD_CYCLES(HOLD_CYCLES), .ACT_CYCLES(ACT_CYCLES)) u_seq (
    .clk(clk), .rst_n(rst_n), .timeout(timeout), .hib_req(hib_req),
    .irq_pending(irq_pending), .batt_inhibit(batt_inhibit),
    .activate_req(activate_req), .reset_switch(reset_switch),
    .vec(vec), .running(running), .set_batt(set_batt)
  );

  pss_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr_en), .addr(reg_addr),
    .wdata(reg_wdata), .set_tmo(timeout), .set_batt(set_batt),
    .rdata(reg_rdata), .wd_clr(wd_clr)
  );

  assign periph_rst   = vec.periph_rst;
  assign gpio_rst     = vec.gpio_rst;
  assign cpu_rst      = vec.cpu_rst;
  assign cpu_clk_stop = vec.clk_stop;

  // R10: the GPIO reset only ever comes with the peripheral reset
  a_r10_gpio_within_periph: assert property (@(posedge clk) disable iff (!rst_n)
    gpio_rst |-> periph_rst);
  // R10: a CPU reset joined to a peripheral reset follows it
  a_r10_periph_leads_cpu: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(cpu_rst) && periph_rst) |-> $past(periph_rst));
  // R3: a watchdog expiry starts with both peripheral resets
  a_r3_timeout_starts_seq: assert property (@(posedge clk) disable iff (!rst_n)
    timeout |=> (periph_rst && gpio_rst && !cpu_rst));
endmodule

// File: tb/pwr_shutdown_seq_test.sv
module pwr_shutdown_seq_test;
  localparam int WDL = 8;
  localparam int HLD = 4;
  localparam int ACT = 3;

  logic clk = 0, rst_n = 0;
  logic slow_tick = 0, activate_req = 0, reset_switch = 0, hib_req = 0;
  logic irq_pending = 0, batt_inhibit = 0, reg_wr_en = 0, reg_addr = 0;
  logic [1:0] reg_wdata = 0;
  logic [1:0] reg_rdata;
  logic periph_rst, gpio_rst, cpu_rst, cpu_clk_stop;

  int errors = 0, checks = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  pwr_shutdown_seq #(.WD_LIMIT(WDL), .HOLD_CYCLES(HLD), .ACT_CYCLES(ACT)) uut (
    .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick), .activate_req(activate_req),
    .reset_switch(reset_switch), .hib_req(hib_req), .irq_pending(irq_pending),
    .batt_inhibit(batt_inhibit), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .periph_rst(periph_rst),
    .gpio_rst(gpio_rst), .cpu_rst(cpu_rst), .cpu_clk_stop(cpu_clk_stop)
  );

  // vector order {clk_stop, cpu_rst, gpio_rst, periph_rst}
  int    exp_v[$];
  int    exp_d[$];
  string exp_t[$];

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic push(string tag, int v, int d);
    exp_t.push_back(tag); exp_v.push_back(v); exp_d.push_back(d);
  endtask

  // monitor: closes one output segment per change and scores it
  bit mon_on = 0, mon_started = 0;
  int prev_v, dur;
  always @(negedge clk) begin
    int v;
    v = {28'd0, cpu_clk_stop, cpu_rst, gpio_rst, periph_rst};
    if (mon_on) begin
      if (!mon_started) begin
        mon_started = 1; prev_v = v; dur = 1;
      end else if (v != prev_v) begin
        if (exp_v.size() == 0) begin
          chk("unexpected output change", prev_v, 'hF);
        end else begin
          string t; int ev, ed;
          t = exp_t.pop_front(); ev = exp_v.pop_front(); ed = exp_d.pop_front();
          chk({t, " vector"}, prev_v, ev);
          if (ed >= 0) chk({t, " duration"}, dur, ed);
        end
        prev_v = v; dur = 1;
      end else begin
        dur++;
      end
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) slow_tick = 1;
      @(negedge clk) slow_tick = 0;
    end
  endtask

  task automatic wr(logic a, logic [1:0] d);
    @(negedge clk); reg_wr_en = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr_en = 0;
  endtask

  task automatic rd(logic a, output int d);
    @(negedge clk); reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic pulse(ref logic s);
    @(negedge clk) s = 1;
    @(negedge clk) s = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: run hung, actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int d;
    cyc(3);
    // R1 reset state
    chk("R1 reset outputs", {cpu_clk_stop, cpu_rst, gpio_rst, periph_rst}, 4'b0100);
    reg_addr = 1; #1;
    chk("R1 reset flags", reg_rdata, 0);
    push("R1 power-on activation", 4'b0100, -1);
    rst_n = 1; mon_on = 1;
    cyc(10);
    chk("R1 running after activation", {cpu_clk_stop, cpu_rst, gpio_rst, periph_rst}, 0);

    // R2 clear keeps the watchdog quiet
    ticks(WDL - 1); wr(1'b0, 2'b01); ticks(WDL - 1);
    rd(1'b1, d); chk("R2 clear prevents timeout", d, 0);

    // R2/R3 expiry and sequence
    push("R3 running before timeout", 4'b0000, -1);
    push("R3 periph+gpio hold", 4'b0011, HLD);
    push("R3 cpu cold reset hold", 4'b0111, HLD);
    push("R3 reactivation", 4'b0100, ACT);
    ticks(WDL); cyc(20);
    rd(1'b1, d); chk("R3 timeout flag set", d, 1);
    wr(1'b1, 2'b11); rd(1'b1, d); chk("R9 write one keeps flag", d, 1);

    // R4 sleep with pending interrupt
    irq_pending = 1; pulse(hib_req); cyc(5); irq_pending = 0;
    chk("R4 sleep ignored", {cpu_clk_stop, cpu_rst, gpio_rst, periph_rst}, 0);

    // R5 sleep
    push("R5 running before sleep", 4'b0000, -1);
    push("R5 clock stop alone", 4'b1000, 1);
    push("R5 periph reset in sleep", 4'b1001, HLD);
    pulse(hib_req); cyc(10);
    chk("R5 off state", {cpu_clk_stop, cpu_rst, gpio_rst, periph_rst}, 4'b1000);
    rd(1'b1, d); chk("R5 flags unchanged", d, 1);
    wr(1'b1, 2'b00); rd(1'b1, d); chk("R9 write zero clears", d, 0);
    rd(1'b0, d); chk("R9 control reads zero", d, 0);

    // R6 disarmed while off
    ticks(3 * WDL);
    rd(1'b1, d); chk("R6 no timeout while off", d, 0);

    // R7 wake
    push("R7 off before wake", 4'b1000, -1);
    push("R7 activation from off", 4'b0100, ACT);
    pulse(activate_req); cyc(8);
    chk("R7 running after wake", {cpu_clk_stop, cpu_rst, gpio_rst, periph_rst}, 0);

    // R6/R7 reset switch reloads the watchdog
    ticks(WDL - 3);
    push("R7 running before switch", 4'b0000, -1);
    push("R7 switch activation", 4'b0100, ACT);
    pulse(reset_switch); cyc(8);
    ticks(WDL - 3);
    rd(1'b1, d); chk("R6 reload on restart", d, 0);

    // R8 inhibit outside activation ignored
    batt_inhibit = 1; cyc(4); batt_inhibit = 0;
    rd(1'b1, d); chk("R8 inhibit ignored while running", d, 0);

    // go off again, then abort a wake with a clear in the same cycle
    push("R5 running before sleep 2", 4'b0000, -1);
    push("R5 clock stop alone 2", 4'b1000, 1);
    push("R5 periph reset in sleep 2", 4'b1001, HLD);
    pulse(hib_req); cyc(10);
    push("R8 off before wake", 4'b1000, -1);
    push("R8 aborted activation", 4'b0100, 1);
    push("R8 periph hold", 4'b0001, HLD);
    push("R8 periph+cpu hold", 4'b0101, HLD);
    batt_inhibit = 1;
    @(negedge clk) activate_req = 1;
    @(negedge clk) begin activate_req = 0; reg_wr_en = 1; reg_addr = 1; reg_wdata = 0; end
    @(negedge clk) reg_wr_en = 0;
    batt_inhibit = 0;
    cyc(15);
    chk("R8 off after abort", {cpu_clk_stop, cpu_rst, gpio_rst, periph_rst}, 4'b1000);
    rd(1'b1, d); chk("R9 set beats same-cycle clear", d, 2);
    wr(1'b1, 2'b01); rd(1'b1, d); chk("R9 clear battery flag", d, 0);

    cyc(3);
    chk("R10 all segments seen", exp_v.size(), 0);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule